// File: doc/BRIEF.md
# Link Hot-Reset Substate Controller

This block implements the hot-reset substate of a serial link training state machine for a PCI Express-style port. The parent state machine brings it in through one of two entry requests. A directed entry means a higher layer asked for the reset. A forwarded entry means a recovery stage already saw the link partner request a hot reset. While the block is active, it asks every configured lane to transmit TS1 ordered sets with the hot-reset control bit set, carrying the configured link number and that lane's own lane number.

On the receive side, the block watches decoded ordered-set events for each lane. A trigger is two matching hot-reset TS1s in a row on any one configured lane. Each trigger clears LinkUp. On a switch upstream port that is not a crosslink, the trigger also raises a request that the downstream ports enter hot reset. A timer of about 2 ms, sized from the clock frequency, bounds the stay. The block leaves toward Detect with a single-cycle pulse.

The two entries differ in what a trigger does. In directed mode, a trigger ends the state unless the higher layer asks to stay; if it does, the block remains until that request drops. In forwarded mode, every trigger restarts the timer, and the block leaves only when the timer runs out with no further trigger.

Top module: `hrst_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no entry request, in_state, ts1_send, ts1_hot_bit, ts1_link_num, ts1_lane_nums, linkup_clear, to_detect and dsp_hot_req are all zero.
- R2: An entry request sampled while idle makes in_state 1 after that edge. While in_state is 1, ts1_send equals lane_active_mask, ts1_hot_bit is 1, ts1_link_num equals own_link_num, and each lane's 5-bit slice of ts1_lane_nums (lane i at bits 5i+4..5i) equals the same slice of own_lane_nums.
- R3: A trigger is two consecutive ordered-set events on one lane that both match. A match has os_is_ts1=1, os_hot_bit=1, the lane's 8-bit link number equal to own_link_num and the lane's lane number equal to its own slice. Any non-matching event on that lane between the two cancels the pair. Pairs do not overlap: a third matching event starts a new pair. Events on different lanes never combine.
- R4: linkup_clear is 1 for exactly the cycle after the edge that samples the second event of a trigger.
- R5: In directed mode, a trigger with stay_req=0 makes to_detect 1 at the same edge that raises linkup_clear. A trigger with stay_req=1 keeps the block in the state for as long as stay_req stays 1, even past the timeout. The first edge that samples stay_req=0 after that produces the exit.
- R6: The timeout length L is SHORT_CYCLES when SIM_SHORT=1, and otherwise CLK_HZ/500 (2 ms). In directed mode with no trigger, to_detect rises at the L-th edge after the entry edge.
- R7: In forwarded mode, each trigger restarts the timer. to_detect rises at the L-th edge after the edge that sampled the last trigger's second event.
- R8: to_detect is a single-cycle pulse. During that cycle in_state and ts1_send are already 0.
- R9: When sw_upstream=1 and crosslink_port=0, dsp_hot_req becomes 1 at the edge after a trigger and stays 1 until the exit cycle, where it is 0. Otherwise it stays 0.
- R10: A lane whose lane_active_mask bit is 0 gets no ts1_send request, and its received events never form a trigger.
- R11: Entry requests are ignored while in_state is 1. If both requests arrive together while idle, the directed entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_directed | input | 1 | Entry requested by the higher layer (pulse) |
| req_forwarded | input | 1 | Entry forwarded from recovery (pulse) |
| stay_req | input | 1 | Higher layer asks to remain in hot reset |
| sw_upstream | input | 1 | Port is a switch upstream port |
| crosslink_port | input | 1 | Port is a crosslink; suppresses propagation |
| lane_active_mask | input | LANES | Configured lanes |
| own_link_num | input | LINKW | Configured link number |
| own_lane_nums | input | LANES*LANEW | Configured lane number per lane |
| os_valid | input | LANES | Decoded ordered-set event per lane |
| os_is_ts1 | input | LANES | Event is a TS1 |
| os_hot_bit | input | LANES | Hot-reset control bit of the event |
| os_link_num | input | LANES*LINKW | Received link number per lane |
| os_lane_num | input | LANES*LANEW | Received lane number per lane |
| in_state | output | 1 | Block is in the hot-reset substate |
| ts1_send | output | LANES | Per-lane TS1 transmit request |
| ts1_hot_bit | output | 1 | Hot-reset bit for transmitted TS1s |
| ts1_link_num | output | LINKW | Link number for transmitted TS1s |
| ts1_lane_nums | output | LANES*LANEW | Lane number per lane for transmitted TS1s |
| linkup_clear | output | 1 | One-cycle pulse: drive LinkUp to 0 |
| to_detect | output | 1 | One-cycle exit pulse toward Detect |
| dsp_hot_req | output | 1 | Request downstream ports to enter hot reset |

## Verification
The assertions assume that the port-role and lane configuration inputs (sw_upstream, crosslink_port, lane_active_mask, own numbers) hold still while in_state is 1. They also assume that entry requests are single-cycle pulses and that each lane reports at most one ordered-set event per cycle. The bench changes configuration only while the block is idle between scenarios. It drives every event and request for exactly one cycle, on the falling edge. The timeout is shortened to 40 cycles so that restart and expiry can be measured edge by edge.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DWAIT = 2'd1,
    ST_DHOLD = 2'd2,
    ST_FWD   = 2'd3
  } hr_state_e;
endpackage

// File: rtl/hrst_lane_pair.sv
module hrst_lane_pair #(
  parameter int LINKW = 8,
  parameter int LANEW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_en,
  input  logic             ev_valid,
  input  logic             ev_ts1,
  input  logic             ev_hot,
  input  logic [LINKW-1:0] ev_link,
  input  logic [LANEW-1:0] ev_lane,
  input  logic [LINKW-1:0] cfg_link,
  input  logic [LANEW-1:0] cfg_lane,
  output logic             pair_hit
);
  logic half_q, half_d;
  logic ev_match;

  assign ev_match = ev_ts1 && ev_hot && (ev_link == cfg_link) && (ev_lane == cfg_lane);
  assign pair_hit = lane_en && ev_valid && ev_match && half_q;

  always_comb begin
    half_d = half_q;
    if (!lane_en)             half_d = 1'b0;
    else if (ev_valid) begin
      if (!ev_match)          half_d = 1'b0;
      else if (half_q)        half_d = 1'b0;
      else                    half_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  // R3
  pair_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |=> !half_q);
  // R10
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> !half_q);
endmodule

// File: rtl/hrst_timer.sv
module hrst_timer #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic at_last;

  assign at_last = (cnt_q == LAST);
  assign expired = run && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)              cnt_d = '0;
    else if (run && !at_last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/hrst_fsm.sv
module hrst_fsm
  import hrst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_dir,
  input  logic req_fwd,
  input  logic stay,
  input  logic any_hit,
  input  logic expired,
  input  logic is_up,
  input  logic is_xlink,
  output logic active,
  output logic tmr_restart,
  output logic tmr_run,
  output logic exit_q,
  output logic luc_q,
  output logic dsp_q
);
  hr_state_e st_q, st_d;
  logic go_exit;
  logic dsp_d;

  always_comb begin
    st_d    = st_q;
    go_exit = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_dir)      st_d = ST_DWAIT;
        else if (req_fwd) st_d = ST_FWD;
      end
      ST_DWAIT: begin
        if (any_hit) begin
          if (stay) st_d    = ST_DHOLD;
          else      go_exit = 1'b1;
        end else if (expired) begin
          go_exit = 1'b1;
        end
      end
      ST_DHOLD: if (!stay) go_exit = 1'b1;
      ST_FWD:   if (!any_hit && expired) go_exit = 1'b1;
      default:  st_d = ST_IDLE;
    endcase
    if (go_exit) st_d = ST_IDLE;
  end

  assign active      = (st_q != ST_IDLE);
  assign tmr_restart = (st_q == ST_IDLE) || ((st_q == ST_FWD) && any_hit);
  assign tmr_run     = (st_q == ST_DWAIT) || (st_q == ST_FWD);

  always_comb begin
    dsp_d = dsp_q;
    if (go_exit || !active)              dsp_d = 1'b0;
    else if (any_hit && is_up && !is_xlink) dsp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      exit_q <= 1'b0;
      luc_q  <= 1'b0;
      dsp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      exit_q <= go_exit;
      luc_q  <= any_hit && active;
      dsp_q  <= dsp_d;
    end
  end

  // R7
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FWD && any_hit) |=> (st_q == ST_FWD));
  // R5
  dhold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DHOLD && stay) |=> (st_q == ST_DHOLD && !exit_q));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !go_exit) |=> active);
endmodule

// File: rtl/hrst_ctrl.sv
module hrst_ctrl #(
  parameter int LANES        = 4,
  parameter int LINKW        = 8,
  parameter int LANEW        = 5,
  parameter int CLK_HZ       = 250000000,
  parameter bit SIM_SHORT    = 1'b0,
  parameter int SHORT_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_directed,
  input  logic                   req_forwarded,
  input  logic                   stay_req,
  input  logic                   sw_upstream,
  input  logic                   crosslink_port,
  input  logic [LANES-1:0]       lane_active_mask,
  input  logic [LINKW-1:0]       own_link_num,
  input  logic [LANES*LANEW-1:0] own_lane_nums,
  input  logic [LANES-1:0]       os_valid,
  input  logic [LANES-1:0]       os_is_ts1,
  input  logic [LANES-1:0]       os_hot_bit,
  input  logic [LANES*LINKW-1:0] os_link_num,
  input  logic [LANES*LANEW-1:0] os_lane_num,
  output logic                   in_state,
  output logic [LANES-1:0]       ts1_send,
  output logic                   ts1_hot_bit,
  output logic [LINKW-1:0]       ts1_link_num,
  output logic [LANES*LANEW-1:0] ts1_lane_nums,
  output logic                   linkup_clear,
  output logic                   to_detect,
  output logic                   dsp_hot_req
);
  localparam int LIMIT = SIM_SHORT ? SHORT_CYCLES : (CLK_HZ / 500);

  logic [LANES-1:0] lane_hit;
  logic any_hit, active, tmr_restart, tmr_run, expired;

  assign any_hit = |lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hrst_lane_pair #(.LINKW(LINKW), .LANEW(LANEW)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_en  (active && lane_active_mask[g]),
      .ev_valid (os_valid[g]),
      .ev_ts1   (os_is_ts1[g]),
      .ev_hot   (os_hot_bit[g]),
      .ev_link  (os_link_num[g*LINKW +: LINKW]),
      .ev_lane  (os_lane_num[g*LANEW +: LANEW]),
      .cfg_link (own_link_num),
      .cfg_lane (own_lane_nums[g*LANEW +: LANEW]),
      .pair_hit (lane_hit[g])
    );
    assign ts1_lane_nums[g*LANEW +: LANEW] =
      (active && lane_active_mask[g]) ? own_lane_nums[g*LANEW +: LANEW] : '0;
  end

  hrst_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .expired (expired)
  );

  hrst_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_dir     (req_directed),
    .req_fwd     (req_forwarded),
    .stay        (stay_req),
    .any_hit     (any_hit),
    .expired     (expired),
    .is_up       (sw_upstream),
    .is_xlink    (crosslink_port),
    .active      (active),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .exit_q      (to_detect),
    .luc_q       (linkup_clear),
    .dsp_q       (dsp_hot_req)
  );

  assign in_state     = active;
  assign ts1_send     = active ? lane_active_mask : '0;
  assign ts1_hot_bit  = active;
  assign ts1_link_num = active ? own_link_num : '0;

  // R4
  linkup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> linkup_clear);
  // R8
  exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_detect |=> !to_detect);
  // R8
  exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_detect |-> (ts1_send == '0 && !in_state));
  // R9
  dsp_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_hot_req |-> (sw_upstream && !crosslink_port && in_state));
  // R10
  mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_hit & ~lane_active_mask) == '0);
endmodule

// File: tb/sim_hrst_ctrl.sv
module sim_hrst_ctrl;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int NW = 5;
  localparam int LEXP = 40;
  localparam logic [7:0] LINK = 8'h5A;

  logic clk = 1'b0;
  logic rst_n;
  logic req_directed, req_forwarded, stay_req, sw_upstream, crosslink_port;
  logic [NL-1:0] lane_active_mask;
  logic [LW-1:0] own_link_num;
  logic [NL*NW-1:0] own_lane_nums;
  logic [NL-1:0] os_valid, os_is_ts1, os_hot_bit;
  logic [NL*LW-1:0] os_link_num;
  logic [NL*NW-1:0] os_lane_num;
  logic in_state, ts1_hot_bit, linkup_clear, to_detect, dsp_hot_req;
  logic [NL-1:0] ts1_send;
  logic [LW-1:0] ts1_link_num;
  logic [NL*NW-1:0] ts1_lane_nums;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hrst_ctrl #(.LANES(NL), .LINKW(LW), .LANEW(NW), .CLK_HZ(200000000),
              .SIM_SHORT(1'b1), .SHORT_CYCLES(LEXP)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_os(input int ln, input bit ts1, input bit hot,
                         input logic [7:0] lk, input logic [4:0] lnm);
    os_valid = '0; os_valid[ln] = 1'b1;
    os_is_ts1[ln] = ts1; os_hot_bit[ln] = hot;
    os_link_num[ln*LW +: LW] = lk; os_lane_num[ln*NW +: NW] = lnm;
    @(negedge clk);
    os_valid = '0;
  endtask

  task automatic send_ok(input int ln);
    send_os(ln, 1'b1, 1'b1, LINK, 5'(ln));
  endtask

  task automatic enter(input bit dir, input bit fwd);
    req_directed = dir; req_forwarded = fwd;
    @(negedge clk);
    req_directed = 1'b0; req_forwarded = 1'b0;
  endtask

  task automatic wait_exit(output int k);
    k = 0;
    while (!to_detect && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_state && ts1_send == 0 && !to_detect && !linkup_clear && !dsp_hot_req,
        "R1 outputs during reset", int'(ts1_send), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!in_state && ts1_send == 0 && !ts1_hot_bit && ts1_link_num == 0 &&
        ts1_lane_nums == 0 && !to_detect && !dsp_hot_req,
        "R1 idle after reset", int'(in_state), 0);
  endtask

  task automatic t_dir_timeout();
    int k;
    enter(1'b1, 1'b0);
    chk(in_state && ts1_send == 4'hF && ts1_hot_bit, "R2 tx request", int'(ts1_send), 15);
    chk(ts1_link_num == LINK, "R2 link number", int'(ts1_link_num), int'(LINK));
    chk(ts1_lane_nums[3*NW +: NW] == 5'd3 && ts1_lane_nums[1*NW +: NW] == 5'd1,
        "R2 lane numbers", int'(ts1_lane_nums[3*NW +: NW]), 3);
    wait_exit(k);
    chk(k == LEXP, "R6 directed timeout edges", k, LEXP);
    chk(ts1_send == 0 && !in_state, "R8 tx off at exit", int'(ts1_send), 0);
    @(negedge clk);
    chk(!to_detect, "R8 exit single cycle", int'(to_detect), 0);
    settle();
  endtask

  task automatic t_dir_pair_exit();
    stay_req = 1'b0;
    enter(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    send_ok(2);
    chk(!linkup_clear && !to_detect, "R3 single event no trigger", int'(linkup_clear), 0);
    send_ok(2);
    chk(linkup_clear, "R4 linkup clear after pair", int'(linkup_clear), 1);
    chk(to_detect && ts1_send == 0, "R5 directed exit on pair", int'(to_detect), 1);
    @(negedge clk);
    chk(!linkup_clear, "R4 linkup clear one cycle", int'(linkup_clear), 0);
    settle();
  endtask

  task automatic t_dir_hold();
    int seen;
    seen = 0;
    stay_req = 1'b1;
    enter(1'b1, 1'b0);
    send_ok(0);
    send_ok(0);
    chk(linkup_clear && !to_detect && in_state, "R5 hold keeps state", int'(to_detect), 0);
    for (int i = 0; i < LEXP + 20; i++) begin
      @(negedge clk);
      if (to_detect || !in_state) seen++;
    end
    chk(seen == 0, "R5 hold outlasts timeout", seen, 0);
    stay_req = 1'b0;
    @(negedge clk);
    chk(to_detect, "R5 exit when hold drops", int'(to_detect), 1);
    settle();
  endtask

  task automatic t_pair_rules();
    enter(1'b0, 1'b1);
    send_ok(1); send_os(1, 1'b1, 1'b1, 8'h33, 5'd1); send_ok(1);
    chk(!linkup_clear, "R3 link mismatch cancels", int'(linkup_clear), 0);
    send_os(1, 1'b1, 1'b1, LINK, 5'd2); send_ok(1);
    chk(!linkup_clear, "R3 lane mismatch cancels", int'(linkup_clear), 0);
    send_os(1, 1'b1, 1'b0, LINK, 5'd1); send_ok(1);
    chk(!linkup_clear, "R3 missing hot bit cancels", int'(linkup_clear), 0);
    send_os(1, 1'b0, 1'b1, LINK, 5'd1); send_ok(1);
    chk(!linkup_clear, "R3 non-TS1 cancels", int'(linkup_clear), 0);
    send_ok(0); send_ok(3);
    chk(!linkup_clear, "R3 lanes do not combine", int'(linkup_clear), 0);
    send_ok(0);
    chk(linkup_clear, "R3 pair on lane0", int'(linkup_clear), 1);
    send_ok(0);
    chk(!linkup_clear, "R3 pairs do not overlap", int'(linkup_clear), 0);
    send_ok(0);
    chk(linkup_clear, "R3 next pair", int'(linkup_clear), 1);
    begin
      int k;
      wait_exit(k);
      chk(k == LEXP, "R7 exit after last pair", k, LEXP);
    end
    settle();
  endtask

  task automatic t_fwd_restart(input bit up, input bit xl);
    int k;
    sw_upstream = up; crosslink_port = xl;
    enter(1'b0, 1'b1);
    repeat (25) @(negedge clk);
    send_ok(2); send_ok(2);
    chk(linkup_clear && in_state && !to_detect, "R7 pair keeps state", int'(in_state), 1);
    chk(dsp_hot_req == (up && !xl), "R9 downstream request", int'(dsp_hot_req), int'(up && !xl));
    repeat (LEXP - 5) @(negedge clk);
    chk(dsp_hot_req == (up && !xl) && in_state, "R9 request held", int'(dsp_hot_req), int'(up && !xl));
    wait_exit(k);
    chk(k == 5, "R7 restarted timeout edges", k, 5);
    chk(!dsp_hot_req, "R9 request dropped at exit", int'(dsp_hot_req), 0);
    sw_upstream = 1'b0; crosslink_port = 1'b0;
    settle();
  endtask

  task automatic t_unconfigured();
    int k;
    lane_active_mask = 4'b0111;
    enter(1'b1, 1'b0);
    chk(ts1_send == 4'b0111, "R10 tx only configured lanes", int'(ts1_send), 7);
    send_ok(3); send_ok(3);
    chk(!linkup_clear && in_state, "R10 unconfigured lane ignored", int'(linkup_clear), 0);
    wait_exit(k);
    chk(k == LEXP - 2, "R10 no exit from masked lane", k, LEXP - 2);
    lane_active_mask = 4'hF;
    settle();
  endtask

  task automatic t_entry_rules();
    int k;
    stay_req = 1'b0;
    enter(1'b0, 1'b1);
    repeat (9) @(negedge clk);
    enter(1'b1, 1'b1);
    wait_exit(k);
    chk(k == LEXP - 10, "R11 entry ignored while busy", k, LEXP - 10);
    settle();
    enter(1'b1, 1'b1);
    send_ok(1); send_ok(1);
    chk(to_detect, "R11 directed wins", int'(to_detect), 1);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_directed = 0; req_forwarded = 0; stay_req = 0;
    sw_upstream = 0; crosslink_port = 0;
    lane_active_mask = 4'hF; own_link_num = LINK;
    for (int i = 0; i < NL; i++) own_lane_nums[i*NW +: NW] = 5'(i);
    os_valid = '0; os_is_ts1 = '0; os_hot_bit = '0;
    os_link_num = '0; os_lane_num = '0;
    @(negedge clk);
    t_reset();
    t_dir_timeout();
    t_dir_pair_exit();
    t_dir_hold();
    t_pair_rules();
    t_fwd_restart(1'b1, 1'b0);
    t_fwd_restart(1'b1, 1'b1);
    t_unconfigured();
    t_entry_rules();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule